// File: doc/BRIEF.md
# Daisy-Chain Converter Readout Controller

This block drives one serial sampling converter, or several wired as a daisy chain. A free-running rate timer requests a sample every programmable number of system clocks. For each accepted sample the controller raises a conversion-start strobe for a programmable number of clocks. It then waits for the converter's busy line to return low. Once busy is low, it pulls chip select low and clocks the whole chain out.

The readout is 16 bits per device, most significant bit first, with one shift clock per bit. The number of shift clocks therefore grows with the parameter for the number of devices. Shift-clock speed comes from a programmable divider. The received words are handed downstream one at a time on a valid/ready stream. Each word carries the position of its device in the chain.

A busy line that stays high too long abandons the cycle and sets an error flag. A sample request that arrives while the controller is still occupied, or while the consumer is not ready, is dropped. Each dropped request is counted.

Top module: `adc_chain_reader`

## Requirements
- R1: After a synchronous active-low reset: `adc_cs_n` is 1, `adc_cnv`, `adc_sck`, `out_valid` and `timeout_err` are 0, and `overrun_cnt` is 0.
- R2: Each accepted sample produces one high pulse on `adc_cnv`. The pulse lasts `start_len` system clocks, or 2 clocks when `start_len` is below 2.
- R3: Chip select falls only after the controller has seen `adc_busy` low following the conversion strobe. `adc_busy` is low in the cycle in which `adc_cs_n` falls.
- R4: Every chip-select-low window holds exactly 16×DEV_COUNT rising edges of `adc_sck`. `adc_sck` stays low whenever `adc_cs_n` is high.
- R5: `adc_sck` stays high for `clk_div` system clocks per pulse. A `clk_div` of 0 acts as 1.
- R6: `adc_sdo` is captured on each rising edge of `adc_sck`. The device is expected to present its first bit when chip select falls and to move to the next bit on each falling edge. Bits arrive most significant first.
- R7: The words of one readout leave in chain order. The first 16 bits received form device 0, the nearest device. `out_dev` gives each word's index, from 0 to DEV_COUNT-1.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_dev` hold their values.
- R9: If `adc_busy` stays high for `busy_timeout` clocks after the strobe, `timeout_err` goes high and the cycle is abandoned: chip select stays high and no word is emitted. `timeout_err` clears when the next conversion starts.
- R10: A rate tick that arrives while the controller is not idle, or while `out_ready` is low, starts no conversion. It increments `overrun_cnt` by one, and the counter wraps.
- R11: With `enable` high, rate ticks come every `sample_period` clocks. A period of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the sample-rate timer |
| sample_period | input | CNT_W | Clocks between sample requests |
| start_len | input | LEN_W | Conversion-strobe length in clocks (minimum 2) |
| clk_div | input | DIV_W | Shift-clock half period in clocks |
| busy_timeout | input | CNT_W | Longest busy-high wait in clocks |
| adc_busy | input | 1 | Converter busy, synchronous to clk |
| adc_sdo | input | 1 | Serial data from the nearest device |
| adc_cnv | output | 1 | Conversion-start strobe |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_sck | output | 1 | Shift clock, idle low |
| out_valid | output | 1 | Result word valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | WORD_W | Result word |
| out_dev | output | IDX_W | Chain index of the word |
| timeout_err | output | 1 | Busy timeout seen in the last cycle |
| overrun_cnt | output | OVR_W | Wrapping count of dropped samples |

## Verification
A behavioural three-device chain model serves as the converter. Each of its words is built from the conversion number and the device index, so a swapped device order, a reversed bit order or an off-by-one shift each gives a visible miscompare. The readout is tried with several patterns, each aimed at a different fault:
- Several strobe lengths and divider values, including the clamped minimums, separate a correct pulse or half-period count from an off-by-one or an unclamped zero.
- A consumer that asserts ready at random shows whether held words stay stable and whether dropped samples desynchronise the stream.
- A ready signal held low across many ticks, and a converter whose busy never falls, each show that a skipped or abandoned cycle touches neither the serial bus nor the output.

// File: rtl/adc_rd_pkg.sv
// Package: shared types of the chain readout controller.
package adc_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT,
        ST_SHIFT,
        ST_EMIT
    } rd_state_t;
endpackage

// File: rtl/adc_rate_tick.sv
// Sample-rate timer. Gives a one-clock tick every `period` clocks while
// enable is high. A period of 0 acts as 1. Assumes nothing about the consumer.
module adc_rate_tick #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Clamp the period and mark its final count.
    always_comb begin
        last = (period == '0) ? '0 : period - CNT_W'(1);
        tick = enable && (cnt >= last);
    end

    // Free-running counter, held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) cnt <= '0;
        else if (cnt >= last)  cnt <= '0;
        else                   cnt <= cnt + CNT_W'(1);
    end

    assert_tick_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && period != '0) |-> (cnt < period));
endmodule

// File: rtl/adc_sck_gen.sv
// Shift-clock generator. While `run` is high it toggles sck every `div`
// clocks (0 acts as 1), starting low. It makes exactly TOTAL_BITS rising
// edges and pulses `done` on the final falling edge. `rise` flags the clock
// in which sck goes high, and the data is captured then. Assumes run stays
// high until done.
module adc_sck_gen #(
    parameter int DIV_W      = 8,
    parameter int TOTAL_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             rise,
    output logic             done
);
    localparam int BIT_W = $clog2(TOTAL_BITS + 1);
    localparam logic [BIT_W-1:0] ALL = BIT_W'(TOTAL_BITS);

    logic [DIV_W-1:0] hc;
    logic [DIV_W-1:0] hc_last;
    logic [BIT_W-1:0] rises;
    logic             wrap;

    // Half-period end and edge events.
    always_comb begin
        hc_last = (div == '0) ? '0 : div - DIV_W'(1);
        wrap    = run && (hc == hc_last);
        rise    = wrap && !sck && (rises != ALL);
        done    = wrap && sck && (rises == ALL);
    end

    // Half-period counter, sck level and rising-edge count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hc    <= '0;
            sck   <= 1'b0;
            rises <= '0;
        end else begin
            hc <= wrap ? '0 : hc + DIV_W'(1);
            if (rise) begin
                sck   <= 1'b1;
                rises <= rises + BIT_W'(1);
            end else if (wrap && sck) begin
                sck <= 1'b0;
            end
        end
    end

    assert_edge_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rises <= ALL);
    assert_sck_parks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sck);
endmodule

// File: rtl/adc_word_unpack.sv
// Collects the serial bits of the whole chain, then presents them one word
// at a time, device 0 (the first bits received) first. Assumes the bits
// arrive most significant first and that shift and pop never overlap.
module adc_word_unpack #(
    parameter int WORD_W    = 16,
    parameter int DEV_COUNT = 2,
    localparam int IDX_W    = (DEV_COUNT > 1) ? $clog2(DEV_COUNT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              pop,
    output logic [WORD_W-1:0] word,
    output logic [IDX_W-1:0]  dev_idx,
    output logic              last
);
    localparam int TOTAL = WORD_W * DEV_COUNT;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEV_COUNT - 1);

    logic [TOTAL-1:0] sh;

    // Word at the head of the register and end-of-chain flag.
    always_comb begin
        word = sh[TOTAL-1 -: WORD_W];
        last = (dev_idx == LAST_IDX);
    end

    // Bit collection, then word-wise advance on each pop.
    always_ff @(posedge clk) begin
        if (!rst_n)        sh <= '0;
        else if (shift_en) sh <= {sh[TOTAL-2:0], bit_in};
        else if (pop)      sh <= sh << WORD_W;
    end

    // Device index of the word at the head.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)  dev_idx <= '0;
        else if (pop && !last) dev_idx <= dev_idx + IDX_W'(1);
    end

    assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_idx <= LAST_IDX);
    assert_no_mix_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_en && pop));
endmodule

// File: rtl/adc_chain_reader.sv
// Top of the chain readout controller. It sequences the conversion strobe,
// the busy wait with timeout, the chip-select-low readout of 16*DEV_COUNT
// bits and the per-word output stream. It assumes adc_busy and adc_sdo are
// already synchronous to clk, and that busy rises while the strobe is high.
module adc_chain_reader #(
    parameter int DEV_COUNT = 2,
    parameter int WORD_W    = 16,
    parameter int CNT_W     = 16,
    parameter int LEN_W     = 8,
    parameter int DIV_W     = 8,
    parameter int OVR_W     = 8,
    localparam int IDX_W    = (DEV_COUNT > 1) ? $clog2(DEV_COUNT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CNT_W-1:0]  sample_period,
    input  logic [LEN_W-1:0]  start_len,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [CNT_W-1:0]  busy_timeout,
    input  logic              adc_busy,
    input  logic              adc_sdo,
    output logic              adc_cnv,
    output logic              adc_cs_n,
    output logic              adc_sck,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic [IDX_W-1:0]  out_dev,
    output logic              timeout_err,
    output logic [OVR_W-1:0]  overrun_cnt
);
    import adc_rd_pkg::*;

    localparam int TOTAL_BITS = WORD_W * DEV_COUNT;

    rd_state_t        state;
    logic [LEN_W-1:0] len_cnt;
    logic [LEN_W-1:0] len_eff;
    logic [CNT_W-1:0] to_cnt;
    logic [CNT_W-1:0] to_last;
    logic             tick, accept, skip;
    logic             sck_rise, sck_done, pop, last_word;

    adc_rate_tick #(.CNT_W(CNT_W)) i_rate (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .period(sample_period), .tick(tick)
    );

    adc_sck_gen #(.DIV_W(DIV_W), .TOTAL_BITS(TOTAL_BITS)) i_sck (
        .clk(clk), .rst_n(rst_n), .run(state == ST_SHIFT), .div(clk_div),
        .sck(adc_sck), .rise(sck_rise), .done(sck_done)
    );

    adc_word_unpack #(.WORD_W(WORD_W), .DEV_COUNT(DEV_COUNT)) i_unpack (
        .clk(clk), .rst_n(rst_n), .clear(accept), .shift_en(sck_rise),
        .bit_in(adc_sdo), .pop(pop), .word(out_data), .dev_idx(out_dev),
        .last(last_word)
    );

    // Decode outputs, clamps and sample acceptance.
    always_comb begin
        len_eff   = (start_len < LEN_W'(2)) ? LEN_W'(2) : start_len;
        to_last   = (busy_timeout == '0) ? '0 : busy_timeout - CNT_W'(1);
        accept    = tick && (state == ST_IDLE) && out_ready;
        skip      = tick && !accept;
        adc_cnv   = (state == ST_CONV);
        adc_cs_n  = (state != ST_SHIFT);
        out_valid = (state == ST_EMIT);
        pop       = out_valid && out_ready;
    end

    // Main sequencer: strobe, busy wait, shift, emit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            len_cnt     <= '0;
            to_cnt      <= '0;
            timeout_err <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state       <= ST_CONV;
                    len_cnt     <= LEN_W'(1);
                    timeout_err <= 1'b0;
                end
                ST_CONV: if (len_cnt >= len_eff) begin
                    state  <= ST_WAIT;
                    to_cnt <= '0;
                end else begin
                    len_cnt <= len_cnt + LEN_W'(1);
                end
                ST_WAIT: if (!adc_busy) begin
                    state <= ST_SHIFT;
                end else if (to_cnt >= to_last) begin
                    state       <= ST_IDLE;
                    timeout_err <= 1'b1;
                end else begin
                    to_cnt <= to_cnt + CNT_W'(1);
                end
                ST_SHIFT: if (sck_done) state <= ST_EMIT;
                ST_EMIT:  if (out_ready && last_word) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Wrapping count of dropped sample requests.
    always_ff @(posedge clk) begin
        if (!rst_n)    overrun_cnt <= '0;
        else if (skip) overrun_cnt <= overrun_cnt + OVR_W'(1);
    end

    assert_cnv_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cnv) |=> adc_cnv);
    assert_cs_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> $past(!adc_busy));
    assert_cnv_cs_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cnv |-> adc_cs_n);
    assert_sck_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_sck);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_dev)));
    assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (adc_cs_n && !out_valid));
    assert_overrun_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (skip && !adc_cnv) |=> (overrun_cnt == OVR_W'($past(overrun_cnt) + 1'b1)));
endmodule

// File: tb/test_adc_chain_reader.sv
// Scoreboard bench: a three-device chain model pushes the expected words when
// it ends each conversion, and a monitor pops and compares on each handshake.
module test_adc_chain_reader;
    localparam int N     = 3;
    localparam int TOT   = 16 * N;
    localparam int IDX_W = 2;
    localparam int CONV_CYC = 20;
    localparam int PER   = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [15:0] sample_period = 16'(PER);
    logic [7:0]  start_len = 8'd3;
    logic [7:0]  clk_div = 8'd2;
    logic [15:0] busy_timeout = 16'd100;
    logic adc_busy, adc_sdo, adc_cnv, adc_cs_n, adc_sck;
    logic out_valid, out_ready = 1'b1, timeout_err;
    logic [15:0] out_data;
    logic [IDX_W-1:0] out_dev;
    logic [7:0] overrun_cnt;

    int vectors = 0, miscompares = 0;
    int exp_len = 3, exp_div = 2;
    int got = 0, windows = 0, cnv_rises = 0, idle_viol = 0;
    bit stuck = 1'b0, aborted = 1'b0, rand_ready = 1'b0, finished = 1'b0;

    always #10 clk = ~clk;

    adc_chain_reader #(.DEV_COUNT(N)) i_adc_chain_reader (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sample_period(sample_period),
        .start_len(start_len), .clk_div(clk_div), .busy_timeout(busy_timeout),
        .adc_busy(adc_busy), .adc_sdo(adc_sdo), .adc_cnv(adc_cnv),
        .adc_cs_n(adc_cs_n), .adc_sck(adc_sck), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_dev(out_dev),
        .timeout_err(timeout_err), .overrun_cnt(overrun_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] mk_word(input int conv, input int dev);
        return 16'((conv * 16'h2F1B) ^ (dev * 16'h4C07) ^ 16'h8A51);
    endfunction

    // ---- chain model: busy, data load, expected-word push ----
    logic [TOT-1:0] chain = '0;
    logic cnv_d = 1'b0;
    int bcnt = 0, conv_no = 0, base = 0, falls = 0;
    logic [15:0] exp_data[$];
    int exp_dev[$];

    always @(posedge clk) begin
        cnv_d <= adc_cnv;
        if (!rst_n) begin
            adc_busy <= 1'b0;
            aborted  <= 1'b0;
        end else if (adc_cnv && !cnv_d) begin
            adc_busy <= 1'b1;
            bcnt <= CONV_CYC;
        end else if (adc_busy && stuck) begin
            aborted <= 1'b1;
        end else if (adc_busy && aborted) begin
            adc_busy <= 1'b0;
            aborted  <= 1'b0;
        end else if (adc_busy) begin
            if (bcnt <= 1) begin
                adc_busy <= 1'b0;
                base <= falls;
                for (int d = 0; d < N; d++) begin
                    chain[TOT-1-16*d -: 16] <= mk_word(conv_no, d);
                    exp_data.push_back(mk_word(conv_no, d));
                    exp_dev.push_back(d);
                end
                conv_no++;
            end else begin
                bcnt <= bcnt - 1;
            end
        end
    end

    // Device side moves to its next bit on each falling shift clock (R6).
    always @(negedge adc_sck) falls <= falls + 1;
    assign adc_sdo = ((falls - base) >= 0 && (falls - base) < TOT)
                     ? chain[TOT-1-(falls-base)] : 1'b0;

    // ---- output monitor (scoreboard pop), R7 ----
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_data.size() == 0) begin
                chk(1'b0, "R7 unexpected word", int'(out_data), 0);
            end else begin
                logic [15:0] ed;
                int edv;
                ed = exp_data.pop_front();
                edv = exp_dev.pop_front();
                chk(out_data == ed, "R7/R6 data", int'(out_data), int'(ed));
                chk(int'(out_dev) == edv, "R7 device index", int'(out_dev), edv);
            end
            got++;
        end
    end

    // ---- protocol monitor: R2, R3, R4, R5 ----
    int cnv_run = 0, sck_run = 0, rise_cnt = 0;
    logic cs_p = 1'b1, sck_p = 1'b0, cnv_p = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (adc_cnv) cnv_run++;
            else if (cnv_run > 0) begin
                chk(cnv_run == exp_len, "R2 strobe length", cnv_run, exp_len);
                cnv_run = 0;
            end
            if (adc_cnv && !cnv_p) cnv_rises++;
            if (adc_sck) sck_run++;
            else if (sck_run > 0) begin
                chk(sck_run == exp_div, "R5 sck high time", sck_run, exp_div);
                sck_run = 0;
            end
            if (!adc_cs_n && cs_p)
                chk(adc_busy == 1'b0, "R3 cs fall with busy", int'(adc_busy), 0);
            if (!adc_cs_n && adc_sck && !sck_p) rise_cnt++;
            if (adc_cs_n && !cs_p) begin
                chk(rise_cnt == TOT, "R4 edges per window", rise_cnt, TOT);
                rise_cnt = 0;
                windows++;
            end
            if (adc_cs_n && adc_sck) idle_viol++;
        end
        cs_p = adc_cs_n; sck_p = adc_sck; cnv_p = adc_cnv;
    end

    // Random consumer readiness (R8, R10).
    always @(posedge clk) begin
        #2;
        if (rand_ready) out_ready = ($urandom % 4) != 0;
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    task automatic wait_words(input int n);
        int target = got + n;
        for (int c = 0; c < 40000 && got < target; c++) @(posedge clk);
        chk(got >= target, "R7 word count", got, target);
    endtask

    task automatic go_idle();
        @(posedge clk); #2 enable = 1'b0;
        repeat (600) @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int ovr0, cr0, w0, g0;
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(adc_cs_n == 1'b1, "R1 cs_n", int'(adc_cs_n), 1);
        chk(adc_cnv == 1'b0, "R1 cnv", int'(adc_cnv), 0);
        chk(adc_sck == 1'b0, "R1 sck", int'(adc_sck), 0);
        chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        chk(timeout_err == 1'b0, "R1 err", int'(timeout_err), 0);
        chk(overrun_cnt == 8'd0, "R1 overrun", int'(overrun_cnt), 0);

        // Pattern 1: nominal strobe and divider (R2 R4 R5 R6 R7 R11)
        @(posedge clk); #2 enable = 1'b1;
        wait_words(6 * N);
        go_idle();
        chk(overrun_cnt == 8'd0, "R11 no drops at full ready", int'(overrun_cnt), 0);

        // Pattern 2: clamped minimums, strobe 1 -> 2, divider 0 -> 1 (R2 R5)
        start_len = 8'd1; clk_div = 8'd0; exp_len = 2; exp_div = 1;
        enable = 1'b1;
        wait_words(4 * N);
        go_idle();

        // Pattern 3: random backpressure, slower divider (R8 R10)
        start_len = 8'd5; clk_div = 8'd3; exp_len = 5; exp_div = 3;
        rand_ready = 1'b1; enable = 1'b1;
        wait_words(8 * N);
        go_idle();
        rand_ready = 1'b0;
        @(posedge clk); #2 out_ready = 1'b1;
        repeat (600) @(posedge clk);
        #2;

        // Pattern 4: ready low across ten periods -> only drops (R10 R11)
        out_ready = 1'b0;
        ovr0 = int'(overrun_cnt); cr0 = cnv_rises;
        enable = 1'b1;
        repeat (10 * PER) @(posedge clk);
        #2 enable = 1'b0;
        @(negedge clk);
        chk(cnv_rises == cr0, "R10 no strobe while not ready", cnv_rises, cr0);
        chk((int'(overrun_cnt) - ovr0) >= 9 && (int'(overrun_cnt) - ovr0) <= 11,
            "R10/R11 drop count", int'(overrun_cnt) - ovr0, 10);
        @(posedge clk); #2 out_ready = 1'b1;

        // Pattern 5: busy never falls (R9)
        go_idle();
        stuck = 1'b1; w0 = windows; g0 = got; cr0 = cnv_rises;
        enable = 1'b1;
        for (int c = 0; c < 2000 && cnv_rises == cr0; c++) @(posedge clk);
        repeat (150) @(posedge clk);
        #2 enable = 1'b0;
        @(negedge clk);
        chk(timeout_err == 1'b1, "R9 error flag", int'(timeout_err), 1);
        chk(windows == w0, "R9 no readout window", windows, w0);
        chk(got == g0, "R9 no word emitted", got, g0);
        chk(adc_cs_n == 1'b1, "R9 cs held high", int'(adc_cs_n), 1);
        @(posedge clk); #2 stuck = 1'b0;
        repeat (10) @(posedge clk);
        #2 cr0 = cnv_rises; enable = 1'b1;
        for (int c = 0; c < 2000 && cnv_rises == cr0; c++) @(posedge clk);
        @(negedge clk);
        chk(timeout_err == 1'b0, "R9 error cleared on next start", int'(timeout_err), 0);
        wait_words(N);
        go_idle();

        // Drain and protocol summary checks
        chk(exp_data.size() == 0, "R7 scoreboard drained", exp_data.size(), 0);
        chk(idle_viol == 0, "R4 sck with cs high", idle_viol, 0);
        finish_run();
    end
endmodule